// File: doc/BRIEF.md
# Configuration Space Access Controller

This block holds a 256-byte configuration space for one device function and serves read and write requests aimed at it. A request carries a 24-bit packed address with bus, device/function and register offset fields, an access width of one, two or four bytes, and write data. The block answers every request exactly one cycle later with a response strobe and a 32-bit read word. Data is assembled little-endian, so the lowest offset lands in bits 7:0.

Writes land one byte at a time. Each byte passes through a writability rule picked by the layout code in the header-type byte. Reserved command and status bits are cleared before they are stored. A software-positioned capability window can be switched on. Requests that fall wholly inside it leave through a handler port, and the handler's data is returned in place of the local array's. When the window is enabled, the status byte's capability flag is set and the capability pointer byte is loaded. A write that touches the command register raises a one-cycle pulse, so that address-decode logic elsewhere can re-evaluate. Header layouts other than 0 and 1 make the whole space read-only.

Top module: `cfg_space_ctrl`

## Requirements
- R1: A request matches only when address bits 23:16 equal `own_bus` and bits 15:8 equal `own_devfn` (slot in bits 15:11, function in bits 10:8). A read that does not match returns 0xFFFFFFFF, and a write that does not match changes nothing.
- R2: `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low otherwise.
- R3: Length code 0, 1 and 2 selects 1, 2 and 4 bytes. Read byte k comes from offset+k and occupies bits 8k+7:8k. Unused upper bytes read as zero.
- R4: A 4-byte read above offset 0xFC, a 2-byte read above 0xFE, or any access with length code 3 returns 0xFFFFFFFF on a read. With length code 3 a write stores nothing.
- R5: Writes are applied byte by byte, and any byte whose offset would pass 0xFF is dropped.
- R6: With header layout 0 (bits 6:0 of byte 0x0E), these bytes are read-only: 0x00-0x03, 0x08-0x0B, 0x0E, 0x10-0x27, 0x2C-0x2F, 0x30-0x34 and 0x3D. All other bytes are writable.
- R7: With header layout 1, these bytes are read-only: 0x00-0x03, 0x08-0x0B, 0x0E, 0x10-0x17, 0x2C-0x2F, 0x34, 0x38-0x3B and 0x3D. Bytes 0x18-0x1B are writable.
- R8: A write to byte 0x05 stores only bits 2:0. A write to byte 0x06 stores bits 7:5 and 3, stores bits 2:0 as zero, and keeps the stored bit 4.
- R9: The capability window is active while `cap_en` is high and `cap_base` lies in 0x40-0xFE. A matched request with offset >= `cap_base` and offset+bytes < `cap_base`+`cap_size` goes out on the handler port in the same cycle. The read data is `cap_rdata`, masked to the width, and the local array is left unchanged.
- R10: On a rising edge of `cap_en` with a valid base, status byte 0x06 bit 4 is set and byte 0x34 is loaded with `cap_base`.
- R11: `cmd_upd` pulses for one cycle, together with the response, after a matched local write whose byte range overlaps offsets 0x04-0x05.
- R12: After reset the space holds the vendor ID at 0x00, the device ID at 0x02, the revision at 0x08, the class code at 0x09-0x0B, the header type at 0x0E, the subsystem vendor at 0x2C and the subsystem ID at 0x2E. Every other byte is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Bus, device/function, register offset |
| req_len | input | 2 | Width code: 0=1, 1=2, 2=4 bytes, 3=invalid |
| req_wdata | input | 32 | Write data, little-endian |
| own_bus | input | 8 | Bus number this function answers on |
| own_devfn | input | 8 | Device/function number this function answers to |
| cap_en | input | 1 | Capability window enable |
| cap_base | input | 8 | First offset of the capability window |
| cap_size | input | 8 | Length of the capability window in bytes |
| cap_rdata | input | 32 | Read data from the capability handler |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| cmd_upd | output | 1 | Pulse after a write touching the command register |
| cap_req_valid | output | 1 | Request diverted to the capability handler |
| cap_req_write | output | 1 | Diverted request is a write |
| cap_req_off | output | 8 | Offset of the diverted request |
| cap_req_len | output | 2 | Width code of the diverted request |
| cap_req_wdata | output | 32 | Write data of the diverted request |

## Verification
The assertions check these on every cycle: the one-cycle response timing, all-ones data for reads that miss the bus or device, all-ones data for 4-byte reads past 0xFC, zeroed upper bytes on single-byte reads, that the handler strobe only fires inside an enabled window, and that the command pulse only follows a write. The stored effects can be seen only by writing and reading back in the bench's scenarios. These are the per-byte writability of both header layouts, the cleared reserved bits, dropped bytes at the top of the space, the capability flag and pointer, and an array left untouched by diverted writes.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int CFG_BYTES  = 256;
    localparam int OFF_W      = 8;
    localparam int LANES      = 4;
    localparam int DATA_W     = LANES * 8;
    localparam int LEN_W      = 2;
    localparam int ADDR_W     = 3 * OFF_W;

    localparam logic [7:0] CMD_LO_OFF    = 8'h04;
    localparam logic [7:0] CMD_HI_OFF    = 8'h05;
    localparam logic [7:0] STAT_LO_OFF   = 8'h06;
    localparam logic [7:0] HDR_OFF       = 8'h0E;
    localparam logic [7:0] CAPPTR_OFF    = 8'h34;
    localparam logic [7:0] CAP_BASE_MIN  = 8'h40;
    localparam logic [7:0] CAP_BASE_MAX  = 8'hFE;
    localparam logic [7:0] CMD_HI_KEEP   = 8'h07;
    localparam logic [7:0] STAT_LO_KEEP  = 8'hE8;
    localparam int         STAT_CAP_BIT  = 4;
    localparam logic [7:0] STAT_CAP_MASK = 8'h10;

    typedef enum logic [LEN_W-1:0] {
        LEN_B1  = 2'd0,
        LEN_B2  = 2'd1,
        LEN_B4  = 2'd2,
        LEN_BAD = 2'd3
    } acc_len_e;

    typedef struct packed {
        logic [7:0] bus;
        logic [7:0] devfn;
        logic [7:0] off;
    } cfg_addr_t;

    typedef struct packed {
        logic       hit;
        logic       cap;
        logic       rd_ok;
        logic [2:0] nbytes;
        logic [7:0] off;
    } cfg_dec_t;

    function automatic logic [2:0] len_bytes(acc_len_e l);
        case (l)
            LEN_B1:  return 3'd1;
            LEN_B2:  return 3'd2;
            LEN_B4:  return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic in_rng(logic [7:0] o, logic [7:0] lo, logic [7:0] hi);
        return (o >= lo) && (o <= hi);
    endfunction

    function automatic logic cap_base_ok(logic [7:0] b);
        return in_rng(b, CAP_BASE_MIN, CAP_BASE_MAX);
    endfunction

    // Per-byte writability, chosen by the header layout code.
    function automatic logic byte_writable(logic [6:0] layout, logic [7:0] o);
        logic ro;
        ro = in_rng(o, 8'h00, 8'h03) || in_rng(o, 8'h08, 8'h0B) ||
             (o == HDR_OFF) || in_rng(o, 8'h2C, 8'h2F) ||
             (o == CAPPTR_OFF) || (o == 8'h3D);
        case (layout)
            7'd0:    ro = ro || in_rng(o, 8'h10, 8'h27) || in_rng(o, 8'h30, 8'h33);
            7'd1:    ro = ro || in_rng(o, 8'h10, 8'h17) || in_rng(o, 8'h38, 8'h3B);
            default: ro = 1'b1;
        endcase
        return !ro;
    endfunction

    // Clear reserved command/status bits; the capability flag is not writable.
    function automatic logic [7:0] fix_reserved(logic [7:0] o, logic [7:0] nb, logic [7:0] ob);
        case (o)
            CMD_HI_OFF:  return nb & CMD_HI_KEEP;
            STAT_LO_OFF: return (nb & STAT_LO_KEEP) | (ob & STAT_CAP_MASK);
            default:     return nb;
        endcase
    endfunction

    function automatic logic [7:0] reset_byte(
        logic [7:0] o, logic [15:0] vid, logic [15:0] did, logic [7:0] rev,
        logic [23:0] cls, logic [7:0] hdr, logic [15:0] svid, logic [15:0] sid);
        case (o)
            8'h00:   return vid[7:0];
            8'h01:   return vid[15:8];
            8'h02:   return did[7:0];
            8'h03:   return did[15:8];
            8'h08:   return rev;
            8'h09:   return cls[7:0];
            8'h0A:   return cls[15:8];
            8'h0B:   return cls[23:16];
            HDR_OFF: return hdr;
            8'h2C:   return svid[7:0];
            8'h2D:   return svid[15:8];
            8'h2E:   return sid[7:0];
            8'h2F:   return sid[15:8];
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfg_decode.sv
module cfg_decode import cfg_pkg::*; (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [7:0]        own_bus,
    input  logic [7:0]        own_devfn,
    input  logic              cap_en,
    input  logic [7:0]        cap_base,
    input  logic [7:0]        cap_size,
    output cfg_dec_t          dec
);
    cfg_addr_t  a;
    acc_len_e   lc;
    logic [2:0] nb;
    logic [8:0] end_x;
    logic [8:0] lim_x;
    logic       win_on;

    always_comb begin
        a      = addr;
        lc     = acc_len_e'(len);
        nb     = len_bytes(lc);
        end_x  = {1'b0, a.off} + {6'd0, nb};
        lim_x  = {1'b0, cap_base} + {1'b0, cap_size};
        win_on = cap_en && cap_base_ok(cap_base);

        dec.off    = a.off;
        dec.nbytes = nb;
        dec.hit    = (a.bus == own_bus) && (a.devfn == own_devfn);
        case (lc)
            LEN_B1:  dec.rd_ok = 1'b1;
            LEN_B2:  dec.rd_ok = (a.off <= 8'hFE);
            LEN_B4:  dec.rd_ok = (a.off <= 8'hFC);
            default: dec.rd_ok = 1'b0;
        endcase
        dec.cap = win_on && (nb != 3'd0) && (a.off >= cap_base) && (end_x < lim_x);
    end
endmodule

// File: rtl/cfg_wlane.sv
module cfg_wlane import cfg_pkg::*; #(
    parameter int LANE = 0
) (
    input  logic       wr_go,
    input  cfg_dec_t   dec,
    input  logic [6:0] layout,
    input  logic [7:0] old_byte,
    input  logic [7:0] new_byte,
    output logic       we,
    output logic [7:0] waddr,
    output logic [7:0] wbyte
);
    logic [8:0] tgt;

    always_comb begin
        tgt   = {1'b0, dec.off} + 9'(LANE);
        waddr = tgt[7:0];
        we    = wr_go && (3'(LANE) < dec.nbytes) && !tgt[8] &&
                byte_writable(layout, tgt[7:0]);
        wbyte = fix_reserved(tgt[7:0], new_byte, old_byte);
    end
endmodule

// File: rtl/cfg_store.sv
module cfg_store import cfg_pkg::*; #(
    parameter logic [15:0] VENDOR_ID     = 16'h0000,
    parameter logic [15:0] DEVICE_ID     = 16'h0000,
    parameter logic [7:0]  REVISION      = 8'h00,
    parameter logic [23:0] CLASS_CODE    = 24'h000000,
    parameter logic [7:0]  HEADER_TYPE   = 8'h00,
    parameter logic [15:0] SUBSYS_VENDOR = 16'h0000,
    parameter logic [15:0] SUBSYS_ID     = 16'h0000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LANES-1:0]      we,
    input  logic [LANES-1:0][7:0] waddr,
    input  logic [LANES-1:0][7:0] wbyte,
    input  logic [7:0]            rd_off,
    input  logic                  cap_arm,
    input  logic [7:0]            cap_base,
    output logic [LANES-1:0][7:0] rbyte,
    output logic [7:0]            layout_byte
);
    logic [7:0] mem [CFG_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CFG_BYTES; i++)
                mem[i] <= reset_byte(8'(i), VENDOR_ID, DEVICE_ID, REVISION,
                                     CLASS_CODE, HEADER_TYPE, SUBSYS_VENDOR, SUBSYS_ID);
        end else begin
            for (int l = 0; l < LANES; l++)
                if (we[l]) mem[waddr[l]] <= wbyte[l];
            if (cap_arm) begin
                mem[STAT_LO_OFF][STAT_CAP_BIT] <= 1'b1;
                mem[CAPPTR_OFF]                <= cap_base;
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_rd
        assign rbyte[l] = mem[rd_off + 8'(l)];
    end

    assign layout_byte = mem[HDR_OFF];
endmodule

// File: rtl/cfg_space_ctrl.sv
module cfg_space_ctrl import cfg_pkg::*; #(
    parameter logic [15:0] VENDOR_ID     = 16'h1AB3,
    parameter logic [15:0] DEVICE_ID     = 16'h7C21,
    parameter logic [7:0]  REVISION      = 8'h05,
    parameter logic [23:0] CLASS_CODE    = 24'h020000,
    parameter logic [7:0]  HEADER_TYPE   = 8'h00,
    parameter logic [15:0] SUBSYS_VENDOR = 16'h5E10,
    parameter logic [15:0] SUBSYS_ID     = 16'h0042
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [7:0]        own_bus,
    input  logic [7:0]        own_devfn,
    input  logic              cap_en,
    input  logic [7:0]        cap_base,
    input  logic [7:0]        cap_size,
    input  logic [DATA_W-1:0] cap_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              cmd_upd,
    output logic              cap_req_valid,
    output logic              cap_req_write,
    output logic [7:0]        cap_req_off,
    output logic [LEN_W-1:0]  cap_req_len,
    output logic [DATA_W-1:0] cap_req_wdata
);
    cfg_dec_t              dec;
    logic                  wr_go;
    logic [LANES-1:0]      we;
    logic [LANES-1:0][7:0] waddr;
    logic [LANES-1:0][7:0] wbyte;
    logic [LANES-1:0][7:0] rbyte;
    logic [7:0]            layout_byte;
    logic                  cap_en_q;
    logic                  cap_arm;
    logic [DATA_W-1:0]     rd_word;
    logic [8:0]            last_x;
    logic                  cmd_hit;

    cfg_decode u_dec (
        .addr      (req_addr),
        .len       (req_len),
        .own_bus   (own_bus),
        .own_devfn (own_devfn),
        .cap_en    (cap_en),
        .cap_base  (cap_base),
        .cap_size  (cap_size),
        .dec       (dec)
    );

    assign wr_go = req_valid && req_write && dec.hit && !dec.cap;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        cfg_wlane #(.LANE(l)) u_lane (
            .wr_go    (wr_go),
            .dec      (dec),
            .layout   (layout_byte[6:0]),
            .old_byte (rbyte[l]),
            .new_byte (req_wdata[l*8 +: 8]),
            .we       (we[l]),
            .waddr    (waddr[l]),
            .wbyte    (wbyte[l])
        );
    end

    assign cap_arm = cap_en && !cap_en_q && cap_base_ok(cap_base);

    cfg_store #(
        .VENDOR_ID     (VENDOR_ID),
        .DEVICE_ID     (DEVICE_ID),
        .REVISION      (REVISION),
        .CLASS_CODE    (CLASS_CODE),
        .HEADER_TYPE   (HEADER_TYPE),
        .SUBSYS_VENDOR (SUBSYS_VENDOR),
        .SUBSYS_ID     (SUBSYS_ID)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .we          (we),
        .waddr       (waddr),
        .wbyte       (wbyte),
        .rd_off      (dec.off),
        .cap_arm     (cap_arm),
        .cap_base    (cap_base),
        .rbyte       (rbyte),
        .layout_byte (layout_byte)
    );

    // Read word: little-endian lanes, unused lanes zero, rejected reads all ones.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            if (3'(l) < dec.nbytes)
                rd_word[l*8 +: 8] = dec.cap ? cap_rdata[l*8 +: 8] : rbyte[l];
            else
                rd_word[l*8 +: 8] = 8'h00;
        end
        if (!(dec.hit && dec.rd_ok))
            rd_word = '1;
    end

    always_comb begin
        last_x  = {1'b0, dec.off} + {6'd0, dec.nbytes} - 9'd1;
        cmd_hit = wr_go && (dec.nbytes != 3'd0) &&
                  (dec.off <= CMD_HI_OFF) && (last_x >= {1'b0, CMD_LO_OFF});
    end

    assign cap_req_valid = req_valid && dec.hit && dec.cap;
    assign cap_req_write = req_write;
    assign cap_req_off   = dec.off;
    assign cap_req_len   = req_len;
    assign cap_req_wdata = req_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            cmd_upd   <= 1'b0;
            cap_en_q  <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rd_word : '0;
            cmd_upd   <= cmd_hit;
            cap_en_q  <= cap_en;
        end
    end
endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [23:0] req_addr,
    input logic [1:0]  req_len,
    input logic [7:0]  own_bus,
    input logic [7:0]  own_devfn,
    input logic        cap_en,
    input logic [7:0]  cap_base,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        cmd_upd,
    input logic        cap_req_valid,
    input logic [7:0]  cap_req_off
);
    logic hit;
    assign hit = (req_addr[23:16] == own_bus) && (req_addr[15:8] == own_devfn);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R1
    miss_reads_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !hit) |=> (rsp_rdata == 32'hFFFF_FFFF));

    // R4
    wide_tail_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_len == 2'd2 && req_addr[7:0] > 8'hFC)
        |=> (rsp_rdata == 32'hFFFF_FFFF));

    // R3
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && hit && req_len == 2'd0) |=> (rsp_rdata[31:8] == 24'd0));

    // R9
    cap_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        cap_req_valid |-> (req_valid && cap_en && cap_req_off >= cap_base));

    // R11
    upd_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_upd |-> $past(req_valid && req_write));
endmodule

bind cfg_space_ctrl cfg_space_chk u_chk (.*);

// File: tb/sim_cfg_space_ctrl.sv
`timescale 1ns/1ps
module sim_cfg_space_ctrl;

    typedef struct packed {
        logic        sel;
        logic        wr;
        logic [23:0] addr;
        logic [1:0]  len;
        logic [31:0] wdata;
        logic [31:0] expd;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 36;
    // sel 0 = u0 (layout 0, devfn 0x28), 1 = u1 (layout 1, devfn 0x30); rq = requirement number
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b0, 24'h032800, 2'd2, 32'h0, 32'h7C211AB3, 8'd12}, // R12
        '{1'b0, 1'b0, 24'h032802, 2'd1, 32'h0, 32'h00007C21, 8'd3},  // R3
        '{1'b0, 1'b0, 24'h03280B, 2'd0, 32'h0, 32'h00000002, 8'd12}, // R12
        '{1'b0, 1'b0, 24'h03280E, 2'd0, 32'h0, 32'h00000000, 8'd12}, // R12
        '{1'b1, 1'b0, 24'h03300E, 2'd0, 32'h0, 32'h00000001, 8'd7},  // R7
        '{1'b0, 1'b1, 24'h032800, 2'd2, 32'hFFFFFFFF, 32'h0, 8'd6},
        '{1'b0, 1'b0, 24'h032800, 2'd2, 32'h0, 32'h7C211AB3, 8'd6},  // R6
        '{1'b0, 1'b1, 24'h03283C, 2'd0, 32'h0000005A, 32'h0, 8'd6},
        '{1'b0, 1'b0, 24'h03283C, 2'd0, 32'h0, 32'h0000005A, 8'd6},
        '{1'b0, 1'b1, 24'h03282C, 2'd2, 32'h12345678, 32'h0, 8'd6},
        '{1'b0, 1'b0, 24'h03282C, 2'd2, 32'h0, 32'h00425E10, 8'd6},
        '{1'b0, 1'b1, 24'h032804, 2'd1, 32'h0000FFFF, 32'h0, 8'd8},
        '{1'b0, 1'b0, 24'h032804, 2'd1, 32'h0, 32'h000007FF, 8'd8},  // R8
        '{1'b0, 1'b1, 24'h032806, 2'd0, 32'h000000FF, 32'h0, 8'd8},
        '{1'b0, 1'b0, 24'h032806, 2'd0, 32'h0, 32'h000000E8, 8'd8},
        '{1'b0, 1'b1, 24'h032840, 2'd2, 32'hA1B2C3D4, 32'h0, 8'd3},
        '{1'b0, 1'b0, 24'h032840, 2'd2, 32'h0, 32'hA1B2C3D4, 8'd3},
        '{1'b0, 1'b0, 24'h032841, 2'd1, 32'h0, 32'h0000B2C3, 8'd3},
        '{1'b0, 1'b0, 24'h0328FD, 2'd2, 32'h0, 32'hFFFFFFFF, 8'd4},  // R4
        '{1'b0, 1'b0, 24'h0328FC, 2'd2, 32'h0, 32'h00000000, 8'd4},
        '{1'b0, 1'b0, 24'h0328FF, 2'd1, 32'h0, 32'hFFFFFFFF, 8'd4},
        '{1'b0, 1'b0, 24'h032840, 2'd3, 32'h0, 32'hFFFFFFFF, 8'd4},
        '{1'b0, 1'b1, 24'h0328FE, 2'd2, 32'h44332211, 32'h0, 8'd5},
        '{1'b0, 1'b0, 24'h0328FE, 2'd1, 32'h0, 32'h00002211, 8'd5},  // R5
        '{1'b0, 1'b0, 24'h042840, 2'd2, 32'h0, 32'hFFFFFFFF, 8'd1},  // R1
        '{1'b0, 1'b0, 24'h032900, 2'd2, 32'h0, 32'hFFFFFFFF, 8'd1},
        '{1'b0, 1'b1, 24'h04283C, 2'd0, 32'h00000077, 32'h0, 8'd1},
        '{1'b0, 1'b0, 24'h03283C, 2'd0, 32'h0, 32'h0000005A, 8'd1},
        '{1'b1, 1'b1, 24'h033018, 2'd2, 32'h00402010, 32'h0, 8'd7},
        '{1'b1, 1'b0, 24'h033018, 2'd2, 32'h0, 32'h00402010, 8'd7},
        '{1'b1, 1'b1, 24'h033038, 2'd2, 32'hDEADBEEF, 32'h0, 8'd7},
        '{1'b1, 1'b0, 24'h033038, 2'd2, 32'h0, 32'h00000000, 8'd7},
        '{1'b0, 1'b1, 24'h032818, 2'd2, 32'hDEADBEEF, 32'h0, 8'd6},
        '{1'b0, 1'b0, 24'h032818, 2'd2, 32'h0, 32'h00000000, 8'd6},
        '{1'b0, 1'b1, 24'h032840, 2'd3, 32'h00000000, 32'h0, 8'd4},
        '{1'b0, 1'b0, 24'h032840, 2'd2, 32'h0, 32'hA1B2C3D4, 8'd4}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_len = '0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  own_bus = 8'h03;
    logic        cap_en = 1'b0;
    logic [7:0]  cap_base = 8'h00, cap_size = 8'h00;
    logic [31:0] cap_rdata = '0;
    logic        off_low = 1'b0;
    logic [31:0] zero_w = '0;

    logic        rv0, upd0, cv0, cw0;
    logic [31:0] rd0, cwd0;
    logic [7:0]  coff0;
    logic [1:0]  clen0;
    logic        rv1, upd1, cv1, cw1;
    logic [31:0] rd1, cwd1;
    logic [7:0]  coff1;
    logic [1:0]  clen1;

    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [31:0] g_rd0, g_rd1;
    logic        g_rv0, g_upd0, g_cv, g_cw;
    logic [7:0]  g_coff;

    always #2 clk = ~clk;

    cfg_space_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .own_bus(own_bus), .own_devfn(8'h28), .cap_en(cap_en),
        .cap_base(cap_base), .cap_size(cap_size), .cap_rdata(cap_rdata),
        .rsp_valid(rv0), .rsp_rdata(rd0), .cmd_upd(upd0),
        .cap_req_valid(cv0), .cap_req_write(cw0), .cap_req_off(coff0),
        .cap_req_len(clen0), .cap_req_wdata(cwd0)
    );

    cfg_space_ctrl #(.HEADER_TYPE(8'h01)) u1 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .own_bus(own_bus), .own_devfn(8'h30), .cap_en(off_low),
        .cap_base(8'h00), .cap_size(8'h00), .cap_rdata(zero_w),
        .rsp_valid(rv1), .rsp_rdata(rd1), .cmd_upd(upd1),
        .cap_req_valid(cv1), .cap_req_write(cw1), .cap_req_off(coff1),
        .cap_req_len(clen1), .cap_req_wdata(cwd1)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge with the response captured.
    task automatic do_req(input logic wr, input logic [23:0] a, input logic [1:0] l,
                          input logic [31:0] wd);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_len = l; req_wdata = wd;
        #1;
        g_cv = cv0; g_cw = cw0; g_coff = coff0;
        @(negedge clk);
        g_rv0 = rv0; g_rd0 = rd0; g_rd1 = rd1; g_upd0 = upd0;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 R11 R9: quiet outputs after reset
        chk("R2 reset rsp_valid", {31'd0, rv0}, 32'd0);
        chk("R11 reset cmd_upd", {31'd0, upd0}, 32'd0);
        chk("R9 reset cap_req_valid", {31'd0, cv0}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            do_req(VT[i].wr, VT[i].addr, VT[i].len, VT[i].wdata);
            if (!VT[i].wr)
                chk($sformatf("R%0d vector %0d", VT[i].rq, i),
                    VT[i].sel ? g_rd1 : g_rd0, VT[i].expd);
        end

        // R11: command-overlap pulse
        do_req(1'b1, 24'h032804, 2'd0, 32'h00000006);
        chk("R11 pulse on 0x04 write", {31'd0, g_upd0}, 32'd1);
        chk("R2 response strobe", {31'd0, g_rv0}, 32'd1);
        @(negedge clk);
        chk("R11 pulse is one cycle", {31'd0, upd0}, 32'd0);
        chk("R2 no response when idle", {31'd0, rv0}, 32'd0);
        do_req(1'b1, 24'h032806, 2'd1, 32'h0000FFFF);
        chk("R11 no pulse on status write", {31'd0, g_upd0}, 32'd0);
        do_req(1'b1, 24'h032803, 2'd1, 32'h00000600);
        chk("R11 pulse on 0x03-0x04 overlap", {31'd0, g_upd0}, 32'd1);
        do_req(1'b0, 24'h032804, 2'd0, 32'h0);
        chk("R11 no pulse on read", {31'd0, g_upd0}, 32'd0);

        // R10: capability enable
        cap_base = 8'h60; cap_size = 8'h10; cap_en = 1'b1;
        @(negedge clk); @(negedge clk);
        do_req(1'b0, 24'h032806, 2'd0, 32'h0);
        chk("R10 status capability flag", g_rd0, 32'h000000F8);
        do_req(1'b0, 24'h032834, 2'd0, 32'h0);
        chk("R10 capability pointer", g_rd0, 32'h00000060);

        // R9: window routing
        cap_rdata = 32'hCAFEF00D;
        do_req(1'b0, 24'h032864, 2'd2, 32'h0);
        chk("R9 diverted strobe", {31'd0, g_cv}, 32'd1);
        chk("R9 diverted offset", {24'd0, g_coff}, 32'h64);
        chk("R9 handler data", g_rd0, 32'hCAFEF00D);
        do_req(1'b0, 24'h032862, 2'd0, 32'h0);
        chk("R9 handler data masked", g_rd0, 32'h0000000D);
        do_req(1'b0, 24'h03286C, 2'd2, 32'h0);
        chk("R9 end boundary not diverted", {31'd0, g_cv}, 32'd0);
        chk("R9 end boundary local data", g_rd0, 32'h00000000);
        do_req(1'b1, 24'h032864, 2'd0, 32'h00000099);
        chk("R9 diverted write", {30'd0, g_cv, g_cw}, 32'd3);
        cap_en = 1'b0;
        @(negedge clk);
        do_req(1'b0, 24'h032864, 2'd0, 32'h0);
        chk("R9 local array untouched", g_rd0, 32'h00000000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule